// File: doc/BRIEF.md
# Nibble-Command Register Access Decoder

This block turns a stream of command bytes, arriving from a host FIFO link, into accesses on a small internal register file of 8-bit registers. Each byte has two halves. The upper four bits select an operation and the lower four bits carry a payload nibble.

An 8-bit register address is built from two nibble commands. Write data is staged the same way. The low data nibble is held until the high data nibble arrives, and that second command performs the write. Several writes may follow one address setup, because the address steps forward after each committed write.

A read command places the addressed byte on a response stream that uses a valid/ready handshake. A second form of the read command steps the address forward afterwards, so a run of such commands walks consecutive registers. One example is six registers that hold two 24-bit little-endian counters. While a response byte waits for acceptance, the block takes no further commands.

The register file holds the following:
- a fixed identity byte;
- a scratch byte that returns whatever was last written;
- a mode byte, which is driven out of the block;
- a parameterised bank of general registers.

Top module: `nib_reg_access`

## Requirements
- R1: After reset, `cmd_ready` is 1, `rsp_valid` is 0, `mode_o` is 0x00, the address is 0x00 and the staged low data nibble is 0.
- R2: An accepted byte with upper nibble 0x0 replaces address bits [3:0] with the payload. Upper nibble 0x1 replaces address bits [7:4]. Neither changes the other half.
- R3: Upper nibble 0x2 stages the payload as the low data nibble. Upper nibble 0x3 writes {payload, staged nibble} into the addressed register, and the address then increments by one.
- R4: Upper nibble 0x4 loads the addressed register's byte into the response slot, and `rsp_valid` rises one cycle after the byte is accepted. The address is unchanged.
- R5: Upper nibble 0x5 reads like 0x4 and then increments the address by one, wrapping from 0xFF to 0x00.
- R6: Address 0x00 always reads 0xA6. Writes to it have no effect.
- R7: Address 0x01 is a scratch register that reads back the last byte written (for example 0x55 and 0xAA).
- R8: Address 0x02 is the mode register. Its value appears on `mode_o` one cycle after the committing write.
- R9: Addresses 0x08 to 0x0F are general read/write registers, each reset to 0x00. Six increment-reads starting at 0x08 return 0x08 to 0x0D in order.
- R10: Addresses outside 0x00, 0x01, 0x02 and 0x08 to 0x0F read as 0x00. Writes to them change nothing.
- R11: Bytes with upper nibble 0x6 to 0xF are accepted but change neither the address, nor the staged nibble, nor any register, and produce no response.
- R12: While `rsp_valid` is 1, `cmd_ready` is 0, and `rsp_data` stays stable until a cycle with `rsp_ready` high. `rsp_valid` falls on the edge where it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_byte | input | 8 | Operation in [7:4], payload nibble in [3:0] |
| cmd_ready | output | 1 | Command byte is accepted when this and `cmd_valid` are both high |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Byte read from the register file |
| rsp_ready | input | 1 | Consumer takes the response byte |
| mode_o | output | 8 | Current mode register value |

## Verification
Every register update lands on the clock edge that accepts the command byte. A read response becomes visible one cycle after acceptance, and a mode write reaches `mode_o` after the same single edge. A response leaves on the edge where `rsp_ready` is sampled high, and `cmd_ready` returns in the same cycle.

The bench keeps a behavioural model that advances on every rising edge from the same inputs. It compares `cmd_ready`, `rsp_valid`, `rsp_data` and `mode_o` at every falling edge, which is half a cycle after the edge that moved them. Directed checks sample read data at the first falling edge after the accepting edge, which is exactly where the one-cycle latency puts it.

// File: rtl/nib_reg_pkg.sv
package nib_reg_pkg;

   localparam int NIB_W  = 4;
   localparam int BYTE_W = 2 * NIB_W;

   typedef enum logic [NIB_W-1:0] {
      OP_ADDR_LO    = 4'h0,
      OP_ADDR_HI    = 4'h1,
      OP_DATA_LO    = 4'h2,
      OP_DATA_HI_WR = 4'h3,
      OP_READ       = 4'h4,
      OP_READ_INC   = 4'h5
   } nib_op_e;

   typedef struct packed {
      logic             set_lo;
      logic             set_hi;
      logic             load_dlo;
      logic             write;
      logic             read;
      logic             step;
      logic [NIB_W-1:0] nib;
   } nib_cmd_t;

endpackage

// File: rtl/nib_cmd_decode.sv
module nib_cmd_decode
   import nib_reg_pkg::*;
(
   input  logic              fire_i,
   input  logic [BYTE_W-1:0] cmd_byte_i,
   output nib_cmd_t          cmd_o
);

   logic [NIB_W-1:0] op;

   assign op = cmd_byte_i[BYTE_W-1:NIB_W];

   always_comb begin
      cmd_o     = '0;
      cmd_o.nib = cmd_byte_i[NIB_W-1:0];
      if (fire_i) begin
         case (op)
            OP_ADDR_LO:    cmd_o.set_lo   = 1'b1;
            OP_ADDR_HI:    cmd_o.set_hi   = 1'b1;
            OP_DATA_LO:    cmd_o.load_dlo = 1'b1;
            OP_DATA_HI_WR: begin
               cmd_o.write = 1'b1;
               cmd_o.step  = 1'b1;
            end
            OP_READ:       cmd_o.read = 1'b1;
            OP_READ_INC: begin
               cmd_o.read = 1'b1;
               cmd_o.step = 1'b1;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/nib_addr_ptr.sv
module nib_addr_ptr
   import nib_reg_pkg::*;
#(
   parameter int ADDR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  nib_cmd_t          cmd_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BYTE_W-1:0] wdata_o
);

   logic [NIB_W-1:0] dlo_q;

   initial begin : width_chk
      assert (ADDR_W == 2 * NIB_W)
         else $error("nib_addr_ptr: ADDR_W must be two nibbles");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         dlo_q  <= '0;
      end else begin
         if (cmd_i.set_lo)   addr_o[NIB_W-1:0]      <= cmd_i.nib;
         if (cmd_i.set_hi)   addr_o[ADDR_W-1:NIB_W] <= cmd_i.nib;
         if (cmd_i.load_dlo) dlo_q                  <= cmd_i.nib;
         if (cmd_i.step)     addr_o                 <= addr_o + 1'b1;
      end
   end

   assign wdata_o = {cmd_i.nib, dlo_q};

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i.step |=> addr_o == $past(addr_o) + 1'b1);

   // R2
   addr_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i.set_lo && !cmd_i.step) |=> addr_o[ADDR_W-1:NIB_W] == $past(addr_o[ADDR_W-1:NIB_W]));

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
   import nib_reg_pkg::*;
#(
   parameter int               ADDR_W       = 8,
   parameter logic [BYTE_W-1:0] ID_VALUE    = 8'hA6,
   parameter int               ADDR_ID      = 0,
   parameter int               ADDR_SCRATCH = 1,
   parameter int               ADDR_MODE    = 2,
   parameter logic [BYTE_W-1:0] MODE_RESET  = 8'h00,
   parameter bit               HAS_SCRATCH  = 1'b1,
   parameter int               GP_BASE      = 8,
   parameter int               GP_COUNT     = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [BYTE_W-1:0] rd_data_o,
   output logic [BYTE_W-1:0] mode_o
);

   localparam int GP_IW   = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1;
   localparam int GP_LAST = GP_BASE + GP_COUNT - 1;

   logic [BYTE_W-1:0] gp_q [GP_COUNT];
   logic [BYTE_W-1:0] scratch_rd;
   logic [ADDR_W-1:0] rd_off;
   logic              rd_in_gp;

   initial begin : map_chk
      assert (GP_COUNT >= 1 && GP_LAST < (1 << ADDR_W))
         else $error("nib_regfile: general bank out of address range");
      assert (ADDR_ID != ADDR_SCRATCH && ADDR_ID != ADDR_MODE && ADDR_SCRATCH != ADDR_MODE)
         else $error("nib_regfile: fixed registers overlap");
      assert (ADDR_ID < GP_BASE && ADDR_SCRATCH < GP_BASE && ADDR_MODE < GP_BASE)
         else $error("nib_regfile: fixed registers must sit below the bank");
   end

   // mode register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        mode_o <= MODE_RESET;
      else if (wr_en_i && int'(wr_addr_i) == ADDR_MODE)  mode_o <= wr_data_i;
   end

   // scratch register, present or absent
   generate
      if (HAS_SCRATCH) begin : g_scratch
         logic [BYTE_W-1:0] scratch_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                          scratch_q <= '0;
            else if (wr_en_i && int'(wr_addr_i) == ADDR_SCRATCH) scratch_q <= wr_data_i;
         end
         assign scratch_rd = scratch_q;

         // R7
         scratch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && int'(wr_addr_i) == ADDR_SCRATCH) |=> scratch_q == $past(wr_data_i));
      end else begin : g_no_scratch
         assign scratch_rd = '0;
      end
   endgenerate

   // general register bank
   generate
      for (genvar g = 0; g < GP_COUNT; g++) begin : g_gp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                         gp_q[g] <= '0;
            else if (wr_en_i && int'(wr_addr_i) == GP_BASE + g) gp_q[g] <= wr_data_i;
         end
      end
   endgenerate

   assign rd_off   = rd_addr_i - ADDR_W'(GP_BASE);
   assign rd_in_gp = int'(rd_addr_i) >= GP_BASE && int'(rd_addr_i) <= GP_LAST;

   always_comb begin
      rd_data_o = '0;
      if (int'(rd_addr_i) == ADDR_ID)           rd_data_o = ID_VALUE;
      else if (int'(rd_addr_i) == ADDR_SCRATCH) rd_data_o = scratch_rd;
      else if (int'(rd_addr_i) == ADDR_MODE)    rd_data_o = mode_o;
      else if (rd_in_gp)                        rd_data_o = gp_q[rd_off[GP_IW-1:0]];
   end

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && int'(wr_addr_i) == ADDR_MODE) |=> $stable(mode_o));

endmodule

// File: rtl/nib_rsp_slot.sv
module nib_rsp_slot
   import nib_reg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [BYTE_W-1:0] load_data_i,
   input  logic              rsp_ready_i,
   output logic              rsp_valid_o,
   output logic [BYTE_W-1:0] rsp_data_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_data_o  <= '0;
      end else if (load_i) begin
         rsp_valid_o <= 1'b1;
         rsp_data_o  <= load_data_i;
      end else if (rsp_valid_o && rsp_ready_i) begin
         rsp_valid_o <= 1'b0;
      end
   end

   // R12
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_data_o));

   // R12
   no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_o |-> !load_i);

endmodule

// File: rtl/nib_reg_access.sv
module nib_reg_access
   import nib_reg_pkg::*;
#(
   parameter logic [7:0] ID_VALUE     = 8'hA6,
   parameter int         ADDR_ID      = 0,
   parameter int         ADDR_SCRATCH = 1,
   parameter int         ADDR_MODE    = 2,
   parameter logic [7:0] MODE_RESET   = 8'h00,
   parameter bit         HAS_SCRATCH  = 1'b1,
   parameter int         GP_BASE      = 8,
   parameter int         GP_COUNT     = 8
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic [7:0] cmd_byte,
   output logic       cmd_ready,
   output logic       rsp_valid,
   output logic [7:0] rsp_data,
   input  logic       rsp_ready,
   output logic [7:0] mode_o
);

   localparam int ADDR_W = 2 * NIB_W;

   logic              fire;
   nib_cmd_t          cmd;
   logic [ADDR_W-1:0] addr;
   logic [BYTE_W-1:0] wdata;
   logic [BYTE_W-1:0] rd_data;
   logic [NIB_W-1:0]  opcode;

   initial begin : top_chk
      assert (BYTE_W == 8) else $error("nib_reg_access: byte width must be 8");
   end

   assign cmd_ready = !rsp_valid;
   assign fire      = cmd_valid && cmd_ready;
   assign opcode    = cmd_byte[BYTE_W-1:NIB_W];

   nib_cmd_decode u_decode (
      .fire_i     (fire),
      .cmd_byte_i (cmd_byte),
      .cmd_o      (cmd)
   );

   nib_addr_ptr #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_i   (cmd),
      .addr_o  (addr),
      .wdata_o (wdata)
   );

   nib_regfile #(
      .ADDR_W       (ADDR_W),
      .ID_VALUE     (ID_VALUE),
      .ADDR_ID      (ADDR_ID),
      .ADDR_SCRATCH (ADDR_SCRATCH),
      .ADDR_MODE    (ADDR_MODE),
      .MODE_RESET   (MODE_RESET),
      .HAS_SCRATCH  (HAS_SCRATCH),
      .GP_BASE      (GP_BASE),
      .GP_COUNT     (GP_COUNT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (cmd.write),
      .wr_addr_i (addr),
      .wr_data_i (wdata),
      .rd_addr_i (addr),
      .rd_data_o (rd_data),
      .mode_o    (mode_o)
   );

   nib_rsp_slot u_rsp (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (cmd.read),
      .load_data_i (rd_data),
      .rsp_ready_i (rsp_ready),
      .rsp_valid_o (rsp_valid),
      .rsp_data_o  (rsp_data)
   );

   // R6
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && opcode == 4'h4 && int'(addr) == ADDR_ID) |=> rsp_valid && rsp_data == ID_VALUE);

   // R4
   plain_read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && opcode == 4'h4) |=> rsp_valid && $stable(addr));

   // R11
   ignored_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && opcode > 4'h5) |=> !rsp_valid && $stable(addr) && $stable(mode_o));

endmodule

// File: tb/nib_reg_access_bench.sv
`timescale 1ns/1ps
module nib_reg_access_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       cmd_ready;
   logic       rsp_valid;
   logic [7:0] rsp_data;
   logic       rsp_ready = 1'b0;
   logic [7:0] mode_o;

   int    n_checks = 0;
   int    n_fails  = 0;
   int    cycles   = 0;
   string cur_req  = "R1";
   bit    live     = 1'b0;
   bit    done     = 1'b0;

   // behavioural reference model
   int m_addr = 0, m_dlo = 0, m_rd = 0, m_scr = 0, m_mode = 0;
   bit m_rv = 0;
   int m_gp [8];

   always #2 clk = ~clk;

   nib_reg_access u_nib_reg_access (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_byte  (cmd_byte),
      .cmd_ready (cmd_ready),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .rsp_ready (rsp_ready),
      .mode_o    (mode_o)
   );

   function automatic int model_read(int a);
      if (a == 0) return 8'hA6;
      if (a == 1) return m_scr;
      if (a == 2) return m_mode;
      if (a >= 8 && a <= 15) return m_gp[a-8];
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_addr = 0; m_dlo = 0; m_rd = 0; m_scr = 0; m_mode = 0; m_rv = 0;
         for (int i = 0; i < 8; i++) m_gp[i] = 0;
         live = 1'b1;
      end else begin
         bit acc;
         int wv;
         acc = cmd_valid && !m_rv;
         if (m_rv && rsp_ready) m_rv = 0;
         if (acc) begin
            case (int'(cmd_byte[7:4]))
               0: m_addr = (m_addr & 8'hF0) | int'(cmd_byte[3:0]);
               1: m_addr = (m_addr & 8'h0F) | (int'(cmd_byte[3:0]) << 4);
               2: m_dlo = int'(cmd_byte[3:0]);
               3: begin
                  wv = (int'(cmd_byte[3:0]) << 4) | m_dlo;
                  if (m_addr == 1) m_scr = wv;
                  else if (m_addr == 2) m_mode = wv;
                  else if (m_addr >= 8 && m_addr <= 15) m_gp[m_addr-8] = wv;
                  m_addr = (m_addr + 1) % 256;
               end
               4: begin m_rd = model_read(m_addr); m_rv = 1; end
               5: begin
                  m_rd = model_read(m_addr); m_rv = 1;
                  m_addr = (m_addr + 1) % 256;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && live && !done) begin
         check(cmd_ready == !m_rv, cur_req, "cmd_ready", int'(cmd_ready), int'(!m_rv));
         check(rsp_valid == m_rv, cur_req, "rsp_valid", int'(rsp_valid), int'(m_rv));
         if (m_rv) check(int'(rsp_data) == m_rd, cur_req, "rsp_data", int'(rsp_data), m_rd);
         check(int'(mode_o) == m_mode, cur_req, "mode_o", int'(mode_o), m_mode);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   task automatic send(logic [7:0] b);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_byte  = b;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic set_addr(logic [7:0] a);
      send({4'h0, a[3:0]});
      send({4'h1, a[7:4]});
   endtask

   task automatic write_byte(logic [7:0] d);
      send({4'h2, d[3:0]});
      send({4'h3, d[7:4]});
   endtask

   task automatic read_byte(bit inc, int exp, string req);
      send(inc ? 8'h50 : 8'h40);
      check(rsp_valid == 1'b1, req, "read response valid", int'(rsp_valid), 1);
      check(int'(rsp_data) == exp, req, "read data", int'(rsp_data), exp);
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      cur_req = "R1";
      check(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
      check(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
      check(mode_o == 8'h00, "R1", "mode_o", int'(mode_o), 0);
      read_byte(1'b0, 8'hA6, "R1");

      // R6 identity, write ignored
      cur_req = "R6";
      set_addr(8'h00);
      write_byte(8'h3C);
      set_addr(8'h00);
      read_byte(1'b0, 8'hA6, "R6");

      // R7 scratch
      cur_req = "R7";
      set_addr(8'h01);
      write_byte(8'h55);
      set_addr(8'h01);
      read_byte(1'b0, 8'h55, "R7");
      write_byte(8'hAA);
      set_addr(8'h01);
      read_byte(1'b0, 8'hAA, "R7");

      // R8 mode register drives mode_o
      cur_req = "R8";
      set_addr(8'h02);
      write_byte(8'h3C);
      check(mode_o == 8'h3C, "R8", "mode_o after write", int'(mode_o), 8'h3C);

      // R3 write burst, R9 six-register walk
      cur_req = "R3";
      set_addr(8'h08);
      for (int i = 0; i < 6; i++) write_byte(8'(8 + i));
      cur_req = "R9";
      set_addr(8'h08);
      for (int i = 0; i < 6; i++) read_byte(1'b1, 8 + i, "R9");

      // R4 plain read leaves address put
      cur_req = "R4";
      read_byte(1'b0, 8'h00, "R4");
      read_byte(1'b0, 8'h00, "R4");

      // R2 address nibbles
      cur_req = "R2";
      set_addr(8'h0B);
      read_byte(1'b0, 8'h0B, "R2");
      send(8'h1F);
      send(8'h0A);
      send(8'h10);
      read_byte(1'b0, 8'h0A, "R2");

      // R10 unmapped
      cur_req = "R10";
      set_addr(8'h40);
      write_byte(8'h77);
      set_addr(8'h40);
      read_byte(1'b0, 8'h00, "R10");

      // R11 ignored opcodes
      cur_req = "R11";
      set_addr(8'h09);
      send(8'h24);
      send(8'h6F);
      send(8'hA1);
      send(8'hFF);
      send(8'h35);
      set_addr(8'h09);
      read_byte(1'b0, 8'h54, "R11");

      // R5 wrap on increment read
      cur_req = "R5";
      set_addr(8'hFF);
      read_byte(1'b1, 8'h00, "R5");
      read_byte(1'b0, 8'hA6, "R5");

      // R12 stall and hold
      cur_req = "R12";
      set_addr(8'h08);
      send(8'h40);
      cmd_valid = 1'b1;
      cmd_byte  = 8'h0C;
      for (int i = 0; i < 3; i++) begin
         check(rsp_valid == 1'b1, "R12", "held valid", int'(rsp_valid), 1);
         check(cmd_ready == 1'b0, "R12", "stalled intake", int'(cmd_ready), 0);
         check(int'(rsp_data) == 8'h08, "R12", "held data", int'(rsp_data), 8'h08);
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check(rsp_valid == 1'b0, "R12", "valid after accept", int'(rsp_valid), 0);
      check(cmd_ready == 1'b1, "R12", "intake resumes", int'(cmd_ready), 1);
      read_byte(1'b0, 8'h08, "R12");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule